// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block decides, for each conditional-store or exclusive memory access, whether the access may go ahead or must trap. It takes the result of an address translation that has already been done elsewhere: the page's read and write permission bits, its cache attribute, and any translation-fault cause code. It also takes a flag that says whether a data cache is built in, and a 6-bit atomic-policy register that software programs.

The policy register holds three 2-bit fields, one for each cacheable page kind. The page's cache attribute picks which field applies. A zero field means atomic accesses are not supported for that kind of page, and the access faults. Isolate pages always fault. When no data cache is built in, every page is treated as uncached.

One result is given per request. A translation fault comes first, then a missing permission, then a policy fault. The fault flag and the cause code are registered on the clock edge where the request strobe is high, and they hold until the next request.

Top module: `atomic_gate`

## Requirements
- R1: After reset, and until the first request, `fault_o` is 0 and `cause_o` is 0.
- R2: The effective cache attribute selects a policy field. Attribute 0 (uncached) uses `policy_i[1:0]`, attribute 1 (write-through) uses `policy_i[3:2]` and attribute 2 (write-back) uses `policy_i[5:4]`. A zero field faults. A nonzero field allows the access.
- R3: A policy fault reports cause 3 (load/store error) when `excl_i`=0 (conditional store) and cause 42 (exclusive error) when `excl_i`=1.
- R4: Attribute 3 (isolate) always faults with cause 3, for both access kinds and for any `policy_i` value.
- R5: When `dcache_en_i`=0, `attr_i` is ignored and the access is judged as attribute 0, using `policy_i[1:0]`.
- R6: A conditional store to a page that lacks read or write permission faults with cause 29 (store prohibited). Exclusive accesses ignore the permission bits.
- R7: A nonzero `xlat_cause_i` is reported unchanged as the cause, with the fault flag set, whatever the other inputs are.
- R8: Attributes 4 to 7, with a data cache present, never give a policy fault.
- R9: The priority is translation fault, then permission fault, then policy fault. `fault_o` is 0 exactly when `cause_o` is 0.
- R10: The outputs change only on a clock edge where `req_i` is 1. On any other edge they keep their values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe; inputs are judged on this edge |
| excl_i | input | 1 | 1 = exclusive access, 0 = conditional store |
| perm_rd_i | input | 1 | Page grants read |
| perm_wr_i | input | 1 | Page grants write |
| attr_i | input | 3 | Page cache attribute (0 uncached, 1 write-through, 2 write-back, 3 isolate, 4-7 other) |
| dcache_en_i | input | 1 | A data cache is built in |
| policy_i | input | 6 | Atomic-policy register, three 2-bit fields |
| xlat_cause_i | input | 6 | Translation-fault cause, 0 = no fault |
| fault_o | output | 1 | Access must trap |
| cause_o | output | 6 | Exception cause, 0 when allowed |

## Verification
Every verdict is due one edge after the request: inputs are applied at a falling edge, the rising edge registers them, and the outputs are read at the next falling edge. The outputs are then read again one full idle cycle later, after the inputs have been scrambled with the strobe low, to show they held. The sweep covers every access kind, every permission pair, all eight attributes, both data-cache settings, all 64 policy values, and a clean or faulting translation. The expected cause for each case is worked out arithmetically from the priority rules.

// File: rtl/atomic_gate_pkg.sv
package atomic_gate_pkg;
  localparam int ATTR_W     = 3;
  localparam int FIELD_W    = 2;
  localparam int NUM_FIELDS = 3;
  localparam int POLICY_W   = FIELD_W * NUM_FIELDS;

  localparam logic [ATTR_W-1:0] ATTR_UNCACHED = 3'd0;
  localparam logic [ATTR_W-1:0] ATTR_WTHRU    = 3'd1;
  localparam logic [ATTR_W-1:0] ATTR_WBACK    = 3'd2;
  localparam logic [ATTR_W-1:0] ATTR_ISOLATE  = 3'd3;
endpackage

// File: rtl/ag_attr_sel.sv
module ag_attr_sel
  import atomic_gate_pkg::*;
(
  input  logic [ATTR_W-1:0]   attr_i,
  input  logic                dcache_en_i,
  input  logic [POLICY_W-1:0] policy_i,
  output logic [FIELD_W-1:0]  field_o,
  output logic                policed_o,
  output logic                isolate_o
);
  logic [ATTR_W-1:0]  eff_attr;
  logic [FIELD_W-1:0] fields [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] hit;

  // without a data cache every page behaves as uncached
  assign eff_attr = dcache_en_i ? attr_i : ATTR_UNCACHED;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    assign fields[g] = policy_i[g*FIELD_W +: FIELD_W];
    assign hit[g]    = (eff_attr == ATTR_W'(g));
  end

  always_comb begin
    field_o = '0;
    for (int k = 0; k < NUM_FIELDS; k++) begin
      if (hit[k]) field_o = fields[k];
    end
  end

  assign policed_o = |hit;
  assign isolate_o = (eff_attr == ATTR_ISOLATE);
endmodule

// File: rtl/ag_perm_chk.sv
module ag_perm_chk (
  input  logic excl_i,
  input  logic rd_i,
  input  logic wr_i,
  output logic deny_o
);
  // conditional store needs both read and write; exclusive relies on translation
  assign deny_o = !excl_i && !(rd_i && wr_i);
endmodule

// File: rtl/ag_cause_pick.sv
module ag_cause_pick
  import atomic_gate_pkg::*;
#(
  parameter int CAUSE_W                    = 6,
  parameter logic [CAUSE_W-1:0] C_STORE_NP = 6'd29,
  parameter logic [CAUSE_W-1:0] C_LS_ERR   = 6'd3,
  parameter logic [CAUSE_W-1:0] C_EXCL_ERR = 6'd42
) (
  input  logic [CAUSE_W-1:0] xlat_i,
  input  logic               deny_i,
  input  logic               excl_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               policed_i,
  input  logic               isolate_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    fault_o = 1'b1;
    cause_o = '0;
    if (xlat_i != '0) begin
      cause_o = xlat_i;
    end else if (deny_i) begin
      cause_o = C_STORE_NP;
    end else if (isolate_i) begin
      cause_o = C_LS_ERR;
    end else if (policed_i && field_i == '0) begin
      cause_o = excl_i ? C_EXCL_ERR : C_LS_ERR;
    end else begin
      fault_o = 1'b0;
    end
  end
endmodule

// File: rtl/atomic_gate.sv
module atomic_gate
  import atomic_gate_pkg::*;
#(
  parameter int CAUSE_W                    = 6,
  parameter logic [CAUSE_W-1:0] C_STORE_NP = 6'd29,
  parameter logic [CAUSE_W-1:0] C_LS_ERR   = 6'd3,
  parameter logic [CAUSE_W-1:0] C_EXCL_ERR = 6'd42
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                excl_i,
  input  logic                perm_rd_i,
  input  logic                perm_wr_i,
  input  logic [ATTR_W-1:0]   attr_i,
  input  logic                dcache_en_i,
  input  logic [POLICY_W-1:0] policy_i,
  input  logic [CAUSE_W-1:0]  xlat_cause_i,
  output logic                fault_o,
  output logic [CAUSE_W-1:0]  cause_o
);
  logic [FIELD_W-1:0] field;
  logic               policed, isolate, deny;
  logic               fault_d;
  logic [CAUSE_W-1:0] cause_d;

  ag_attr_sel u_sel (
    .attr_i      (attr_i),
    .dcache_en_i (dcache_en_i),
    .policy_i    (policy_i),
    .field_o     (field),
    .policed_o   (policed),
    .isolate_o   (isolate)
  );

  ag_perm_chk u_perm (
    .excl_i (excl_i),
    .rd_i   (perm_rd_i),
    .wr_i   (perm_wr_i),
    .deny_o (deny)
  );

  ag_cause_pick #(
    .CAUSE_W    (CAUSE_W),
    .C_STORE_NP (C_STORE_NP),
    .C_LS_ERR   (C_LS_ERR),
    .C_EXCL_ERR (C_EXCL_ERR)
  ) u_pick (
    .xlat_i    (xlat_cause_i),
    .deny_i    (deny),
    .excl_i    (excl_i),
    .field_i   (field),
    .policed_i (policed),
    .isolate_i (isolate),
    .fault_o   (fault_d),
    .cause_o   (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      cause_o <= '0;
    end else if (req_i) begin
      fault_o <= fault_d;
      cause_o <= cause_d;
    end
  end
endmodule

// File: rtl/ag_checker.sv
module ag_checker
  import atomic_gate_pkg::*;
#(
  parameter int CAUSE_W                    = 6,
  parameter logic [CAUSE_W-1:0] C_STORE_NP = 6'd29,
  parameter logic [CAUSE_W-1:0] C_LS_ERR   = 6'd3,
  parameter logic [CAUSE_W-1:0] C_EXCL_ERR = 6'd42
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                excl_i,
  input logic                perm_rd_i,
  input logic                perm_wr_i,
  input logic [ATTR_W-1:0]   attr_i,
  input logic                dcache_en_i,
  input logic [POLICY_W-1:0] policy_i,
  input logic [CAUSE_W-1:0]  xlat_cause_i,
  input logic                fault_o,
  input logic [CAUSE_W-1:0]  cause_o
);
  logic clean;
  assign clean = (xlat_cause_i == '0) && (excl_i || (perm_rd_i && perm_wr_i));

  p_xlat_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && xlat_cause_i != '0 |=> fault_o && cause_o == $past(xlat_cause_i));

  p_store_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !excl_i && xlat_cause_i == '0 && !(perm_rd_i && perm_wr_i)
    |=> fault_o && cause_o == C_STORE_NP);

  p_isolate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && clean && dcache_en_i && attr_i == ATTR_ISOLATE
    |=> fault_o && cause_o == C_LS_ERR);

  p_no_cache_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && clean && !dcache_en_i |=> fault_o == ($past(policy_i[1:0]) == 2'b00));

  p_excl_policy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && clean && excl_i && !dcache_en_i && policy_i[1:0] == 2'b00
    |=> cause_o == C_EXCL_ERR);

  p_flag_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == (cause_o != '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(fault_o) && $stable(cause_o));
endmodule

bind atomic_gate ag_checker #(
  .CAUSE_W    (CAUSE_W),
  .C_STORE_NP (C_STORE_NP),
  .C_LS_ERR   (C_LS_ERR),
  .C_EXCL_ERR (C_EXCL_ERR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .excl_i       (excl_i),
  .perm_rd_i    (perm_rd_i),
  .perm_wr_i    (perm_wr_i),
  .attr_i       (attr_i),
  .dcache_en_i  (dcache_en_i),
  .policy_i     (policy_i),
  .xlat_cause_i (xlat_cause_i),
  .fault_o      (fault_o),
  .cause_o      (cause_o)
);

// File: tb/sim_atomic_gate.sv
`timescale 1ns/1ps
module sim_atomic_gate;
  localparam int C_NP = 29, C_LS = 3, C_EX = 42;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, excl_i = 1'b0, perm_rd_i = 1'b0, perm_wr_i = 1'b0;
  logic [2:0] attr_i = '0;
  logic       dcache_en_i = 1'b0;
  logic [5:0] policy_i = '0;
  logic [5:0] xlat_cause_i = '0;
  logic       fault_o;
  logic [5:0] cause_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  atomic_gate u0 (.*);

  task automatic check(string tag, logic f, logic [5:0] c, logic ef, logic [5:0] ec);
    n_chk++;
    if (f !== ef || c !== ec) begin
      n_bad++;
      $display("FAIL %s: fault=%0b cause=%0d expected fault=%0b cause=%0d", tag, f, c, ef, ec);
    end
  endtask

  initial begin
    logic       ef, pf, pc;
    logic [5:0] ec;
    logic [2:0] ea;
    logic [1:0] fld;
    string      tag;
    repeat (3) @(negedge clk_i);
    check("R1", fault_o, cause_o, 1'b0, 6'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", fault_o, cause_o, 1'b0, 6'd0);
    for (int x = 0; x < 2; x++)
    for (int e = 0; e < 2; e++)
    for (int p = 0; p < 4; p++)
    for (int a = 0; a < 8; a++)
    for (int d = 0; d < 2; d++)
    for (int pol = 0; pol < 64; pol++) begin
      req_i = 1'b1; excl_i = e[0]; perm_rd_i = p[0]; perm_wr_i = p[1];
      attr_i = a[2:0]; dcache_en_i = d[0]; policy_i = pol[5:0];
      xlat_cause_i = x[0] ? 6'(7 + pol % 50) : 6'd0;
      // expected verdict, priority per R9
      ea = d[0] ? a[2:0] : 3'd0;
      fld = 2'((pol >> (2 * ea)) & 3);
      if (x[0]) begin
        tag = "R7"; ef = 1; ec = xlat_cause_i;
      end else if (!e[0] && p != 3) begin
        tag = "R6"; ef = 1; ec = 6'(C_NP);
      end else if (ea == 3) begin
        tag = "R4"; ef = 1; ec = 6'(C_LS);
      end else if (ea > 3) begin
        tag = "R8"; ef = 0; ec = 0;
      end else begin
        // R2 field choice; R3 cause by access kind
        tag = d[0] ? "R2" : "R5";
        ef = (fld == 2'b00);
        ec = ef ? (e[0] ? 6'(C_EX) : 6'(C_LS)) : 6'd0;
      end
      @(negedge clk_i);
      check(tag, fault_o, cause_o, ef, ec);
      pf = fault_o; pc = cause_o[0];
      // idle cycle with scrambled inputs: outputs must hold (R10)
      req_i = 1'b0; excl_i = ~excl_i; perm_rd_i = ~perm_rd_i; attr_i = attr_i + 3'd3;
      policy_i = ~policy_i; xlat_cause_i = xlat_cause_i ^ 6'd21;
      @(negedge clk_i);
      check("R10", fault_o, cause_o, ef, ec);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule